// File: doc/BRIEF.md
# Matrix Keypad Scanner and Encoder

The block scans a 20-key switch matrix, arranged as 4 rows by 5 columns, with no help from a host. It drives one column at a time and reads the row lines. When a single key stays closed long enough, the block stores the key's binary number and raises a data-available level. That level stays high for as long as the key is held.

A scan clock enable is derived from the system clock by a prescaler. One scan pass visits every column once. Debouncing counts whole passes: a closure must be seen on a run of consecutive passes before it is accepted, and a release must be seen on a run of consecutive passes before it is accepted.

The code outputs share an input port with other functions, and this block is the lowest-priority user of that port. It presents its code only while the host holds the active-low enable low. At all other times the code lines are released. Here that release is modelled as all-zero data together with a cleared valid flag.

Top module: `keypad_scan_enc`

## Requirements
- R1: During and right after reset, data_avail is 0, col_drive selects column 0 (value 5'b00001), and the stored code is 0.
- R2: col_drive always has exactly one bit set. It steps to the next column every PRESCALE clocks in the order 0,1,2,3,4,0,… and bit i drives column i.
- R3: data_avail rises only after the same key has been seen closed on DEBOUNCE consecutive scan passes (default 4). A closure lasting fewer passes than that never raises it.
- R4: The stored code of the key at row r and column c is r*5 + c. Row r is sensed on row_sense bit r.
- R5: data_avail stays 1 while the key stays closed. It falls only after DEBOUNCE consecutive passes with no closed key.
- R6: The stored code is kept after release until another key is accepted. A key accepted later replaces it with that key's own code.
- R7: While a key is accepted and held, pressing any further key changes neither the code nor data_avail. Nothing new is accepted until every key has been released.
- R8: With oe_n high, key_code is all zeros and code_valid is 0. With oe_n low, code_valid is 1 and key_code shows the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sense | input | 4 | Row lines, 1 = closed key on the driven column |
| col_drive | output | 5 | One-hot column drive |
| oe_n | input | 1 | Active-low enable for the code outputs |
| key_code | output | 5 | Stored key number when enabled, zero otherwise |
| code_valid | output | 1 | High when key_code is being driven |
| data_avail | output | 1 | High while an accepted key is held |

## Verification
Two situations are hard to reach from the ports.

The first is a second key pressed while the first is still held, followed by releasing the first while the second stays down. The stimulus reaches it with a row model that tracks two keys at once. It presses and releases them in overlapping order, each phase lasting several passes, and checks that the first code survives throughout.

The second is a closure or release that falls just short of the debounce count. The stimulus holds it for exactly DEBOUNCE-1 pass lengths. Within that window no more than DEBOUNCE-1 pass boundaries can occur, wherever in a pass the change lands.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic { KP_IDLE = 1'b0, KP_HELD = 1'b1 } kp_state_t;

  // key number: rows are laid out one after another, each holding cols keys
  function automatic int key_index(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/kp_prescale.sv
module kp_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kp_colscan.sv
module kp_colscan #(
  parameter int COLS = 5,
  localparam int IW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [IW-1:0]   col_idx,
  output logic [COLS-1:0] col_drive,
  output logic            pass_end
);
  assign pass_end = tick && (col_idx == IW'(COLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        col_idx <= '0;
    else if (pass_end) col_idx <= '0;
    else if (tick)     col_idx <= col_idx + 1'b1;
  end

  for (genvar i = 0; i < COLS; i++) begin : g_drv
    assign col_drive[i] = (col_idx == IW'(i));
  end
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
  import kp_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 5,
  parameter int DEBOUNCE = 4,
  parameter int CW       = 5,
  localparam int IW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NW = $clog2(DEBOUNCE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            pass_end,
  input  logic [IW-1:0]   col_idx,
  input  logic [ROWS-1:0] row_sense,
  output logic            data_avail,
  output logic [CW-1:0]   held_code
);
  kp_state_t     state;
  logic [NW-1:0] cnt, nxt_cnt;
  logic [CW-1:0] cand, first_code, cur_code, pass_code;
  logic [RW-1:0] cur_row;
  logic          seen, cur_hit, pass_any;

  // lowest closed row on the column being driven
  always_comb begin
    cur_row = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (row_sense[r]) cur_row = RW'(r);
  end
  assign cur_hit  = |row_sense;
  assign cur_code = CW'(key_index(int'(cur_row), int'(col_idx), COLS));

  // result of the pass that ends on this tick, including this sample
  assign pass_any  = seen || (tick && cur_hit);
  assign pass_code = seen ? first_code : cur_code;
  assign nxt_cnt   = (cnt != '0 && pass_code == cand) ? cnt + 1'b1 : NW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      first_code <= '0;
    end else if (pass_end) begin
      seen <= 1'b0;
    end else if (tick && cur_hit && !seen) begin
      seen       <= 1'b1;
      first_code <= cur_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= KP_IDLE;
      cnt        <= '0;
      cand       <= '0;
      held_code  <= '0;
      data_avail <= 1'b0;
    end else if (pass_end) begin
      case (state)
        KP_IDLE: begin
          if (!pass_any) begin
            cnt <= '0;
          end else if (nxt_cnt == NW'(DEBOUNCE)) begin
            held_code  <= pass_code;
            data_avail <= 1'b1;
            state      <= KP_HELD;
            cnt        <= '0;
          end else begin
            cand <= pass_code;
            cnt  <= nxt_cnt;
          end
        end
        default: begin
          if (pass_any) begin
            cnt <= '0;
          end else if (cnt == NW'(DEBOUNCE - 1)) begin
            data_avail <= 1'b0;
            state      <= KP_IDLE;
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/keypad_scan_enc.sv
module keypad_scan_enc #(
  parameter int ROWS     = 4,
  parameter int COLS     = 5,
  parameter int PRESCALE = 4,
  parameter int DEBOUNCE = 4,
  localparam int CW = $clog2(ROWS * COLS),
  localparam int IW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_sense,
  output logic [COLS-1:0] col_drive,
  input  logic            oe_n,
  output logic [CW-1:0]   key_code,
  output logic            code_valid,
  output logic            data_avail
);
  logic          scan_tick;
  logic          pass_end;
  logic [IW-1:0] col_idx;
  logic [CW-1:0] held_code;

  kp_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick)
  );

  kp_colscan #(.COLS(COLS)) u_col (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick),
    .col_idx(col_idx), .col_drive(col_drive), .pass_end(pass_end)
  );

  kp_debounce #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE(DEBOUNCE), .CW(CW)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick), .pass_end(pass_end),
    .col_idx(col_idx), .row_sense(row_sense),
    .data_avail(data_avail), .held_code(held_code)
  );

  assign code_valid = ~oe_n;
  assign key_code   = oe_n ? '0 : held_code;
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int COLS = 5,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [COLS-1:0] col_drive,
  input logic            oe_n,
  input logic [CW-1:0]   key_code,
  input logic            code_valid,
  input logic            data_avail,
  input logic            scan_tick,
  input logic            pass_end,
  input logic [CW-1:0]   held_code
);
  p_col_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_drive) == 1);

  p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(col_drive));

  p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_tick |=> !$stable(col_drive));

  p_rise_at_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> $past(pass_end));

  p_fall_at_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(pass_end));

  p_code_only_at_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_end |=> $stable(held_code));

  p_code_frozen_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && $past(data_avail)) |-> $stable(held_code));

  p_port_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (key_code == '0 && !code_valid));
endmodule

bind keypad_scan_enc kp_checker #(.COLS(COLS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .col_drive(col_drive), .oe_n(oe_n),
  .key_code(key_code), .code_valid(code_valid), .data_avail(data_avail),
  .scan_tick(scan_tick), .pass_end(pass_end), .held_code(held_code)
);

// File: tb/sim_keypad_scan_enc.sv
module sim_keypad_scan_enc;
  localparam int ROWS = 4, COLS = 5, PRE = 4, DEB = 4;
  localparam int PASS = PRE * COLS;
  localparam int NV = 6;
  // row, column, expected key number (row*5+col)
  localparam int VEC [NV][3] = '{'{0,0,0}, '{3,4,19}, '{1,2,7},
                                  '{2,0,10}, '{0,4,4}, '{3,1,16}};

  logic clk = 0, rst_n = 0, oe_n = 1;
  logic [ROWS-1:0] row_sense;
  logic [COLS-1:0] col_drive;
  logic [4:0] key_code;
  logic code_valid, data_avail;
  int total = 0, bad = 0;
  bit done = 0;

  int ka_r = 0, ka_c = 0, kb_r = 0, kb_c = 0;
  bit ka_on = 0, kb_on = 0;

  always #5 clk = ~clk;

  always_comb begin
    row_sense = '0;
    if (ka_on && col_drive[ka_c]) row_sense[ka_r] = 1'b1;
    if (kb_on && col_drive[kb_c]) row_sense[kb_r] = 1'b1;
  end

  keypad_scan_enc #(.ROWS(ROWS), .COLS(COLS), .PRESCALE(PRE), .DEBOUNCE(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .row_sense(row_sense), .col_drive(col_drive),
    .oe_n(oe_n), .key_code(key_code), .code_valid(code_valid), .data_avail(data_avail)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic read_code(input string req, input int exp);
    oe_n = 0; #1;
    chk(req, int'(code_valid), 1);
    chk(req, int'(key_code), exp);
    oe_n = 1; #1;
    chk(req, int'(code_valid), 0);
    chk(req, int'(key_code), 0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [COLS-1:0] prev;
    int k;
    // R1 reset state
    cyc(4);
    chk("R1 avail", int'(data_avail), 0);
    chk("R1 col", int'(col_drive), 1);
    rst_n = 1;
    #1;
    read_code("R1 code", 0);
    // R2 column order and rate
    prev = col_drive;
    k = 0;
    while (col_drive == prev && k < 2 * PRE) begin cyc(1); k++; end
    chk("R2 first step", int'(col_drive), 2);
    for (int s = 2; s < 2 * COLS + 2; s++) begin
      cyc(PRE);
      chk("R2 step", int'(col_drive), 1 << (s % COLS));
    end
    // R3 short glitch rejected
    ka_r = 2; ka_c = 2; ka_on = 1;
    cyc((DEB - 1) * PASS);
    ka_on = 0;
    cyc(3 * PASS);
    chk("R3 glitch", int'(data_avail), 0);
    // table walk: R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      ka_r = VEC[v][0]; ka_c = VEC[v][1]; ka_on = 1;
      cyc((DEB - 1) * PASS);
      chk("R3 early", int'(data_avail), 0);
      cyc(2 * PASS + 2);
      chk("R3 accepted", int'(data_avail), 1);
      read_code("R4 code", VEC[v][2]);
      ka_on = 0;
      cyc((DEB - 1) * PASS);
      chk("R5 still high", int'(data_avail), 1);
      cyc(3 * PASS + 2);
      chk("R5 dropped", int'(data_avail), 0);
      read_code("R6 kept", VEC[v][2]);
    end
    // R7 second key while held
    ka_r = 1; ka_c = 1; ka_on = 1;
    cyc((DEB + 2) * PASS);
    chk("R7 first avail", int'(data_avail), 1);
    kb_r = 2; kb_c = 3; kb_on = 1;
    cyc(2 * DEB * PASS);
    read_code("R7 overlap", 6);
    ka_on = 0;
    cyc(2 * DEB * PASS);
    chk("R7 avail", int'(data_avail), 1);
    read_code("R7 second ignored", 6);
    kb_on = 0;
    cyc((DEB + 2) * PASS);
    chk("R7 released", int'(data_avail), 0);
    read_code("R6 kept after R7", 6);
    // R6 new key replaces
    kb_on = 1;
    cyc((DEB + 2) * PASS);
    chk("R6 new avail", int'(data_avail), 1);
    read_code("R6 replaced", 13);
    kb_on = 0;
    cyc((DEB + 2) * PASS);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule